// File: doc/BRIEF.md
# Trapdoor Timing Configuration Register Bank

This block sits on the device side of an IDE-style task-file port. In normal operation every access on the port goes through to the ordinary task-file registers, which live outside this block. A small bank of timing configuration registers is hidden behind a "trapdoor". Two back-to-back 16-bit reads at port offset 1, followed by a byte write of 0x03 at offset 2, open configuration mode. While the mode is open, byte writes at a few fixed offsets load the per-device read-cycle timing, write-cycle timing, address-setup and control registers. None of these accesses reaches the task file. A byte write of 0x83 at offset 2 closes the mode again.

The block drives the timing values for the device that the port currently addresses, one shared address-setup value, and a flag that shows whether programmed values or strap defaults are in force. A strap probe is also provided: after 0xFF is written at offset 5, the next 16-bit read at offset 5 returns the strapped bus-clock selection in bit 0. The PIO cycle generator that uses these timings is a separate block.

Top module: `trapdoor_cfg_bank`

## Requirements
- R1: After reset the block is locked (`cfg_open`=0) and `strap_override`=0. While `strap_override`=0, all three timing outputs show the strap defaults. With `strap_clk`=0 the defaults are 0x66 for both data timings and 0x30 for address setup. With `strap_clk`=1 they are 0x55 for both data timings and 0x20 for address setup.
- R2: The port opens when two consecutive 16-bit reads at offset 1 are followed by a byte write of 0x03 at offset 2. `cfg_open` goes high in the cycle after that write.
- R3: The tracker returns to idle on any other access placed in the sequence. This includes a read at another offset, a byte-wide read, and a 16-bit write at offset 2. After such an access a byte write of 0x03 does not open the port.
- R4: While locked, every access asserts `tf_access` and a read returns `tf_rdata`, except for the armed strap read of R10. Locked writes leave every timing output unchanged.
- R5: While open, a byte write at offset 0 loads the read timing of the latched device and a byte write at offset 1 loads its write timing. A byte read at offset 0 returns the latched device's read timing on `acc_rdata[7:0]`.
- R6: Byte writes at offset 6 alternate after each opening. The first latches the device number from bit 0 of the data. The second stores the address-setup value of that device.
- R7: A byte write at offset 3 loads the control register. `strap_override` is 1 exactly when that register holds 0x85. Writing any other value restores the strap defaults.
- R8: While `strap_override`=1, `addr_setup` shows the larger of the two devices' programmed address-setup values.
- R9: A byte write of 0x83 at offset 2 while open locks the port in the next cycle. The programmed registers keep their values.
- R10: A byte write of 0xFF at offset 5 arms the strap probe. If the next access is a 16-bit read at offset 5, it returns `strap_clk` in bit 0 with all other bits zero, and `tf_access` stays low. Any access disarms the probe.
- R11: While `strap_override`=1, `rd_timing` and `wr_timing` show the programmed values of the device selected by `dev_sel`.
- R12: While open, no access asserts `tf_access`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A port access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_off | input | 3 | Port register offset |
| acc_wdata | input | 8 | Byte write data |
| acc_rdata | output | 16 | Read data returned to the host |
| tf_access | output | 1 | Access is passed through to the task-file registers |
| tf_rdata | input | 16 | Read data from the task-file registers |
| strap_clk | input | 1 | Strapped bus-clock selection |
| dev_sel | input | 1 | Device currently addressed on the port |
| cfg_open | output | 1 | Configuration mode is open |
| rd_timing | output | 8 | Active read-cycle timing |
| wr_timing | output | 8 | Active write-cycle timing |
| addr_setup | output | 8 | Active shared address-setup timing |
| strap_override | output | 1 | Programmed timings override strap defaults |

## Verification
Some rules are checked on every cycle by the assertions. The port can only open right after a byte write of 0x03 at offset 2. A locked cycle without such a write keeps the port locked. The relock write always closes the port. The task file is never reached while open. The override flag cannot change while locked.

Other behaviours depend on a history of several accesses and only the bench's scenarios can show them. These are the alternation of the misc writes, the per-device register storage, the maximum of the two address-setup values, the strap probe, and the choice between programmed values and defaults.

// File: rtl/tdc_pkg.sv
// Shared encodings for the trapdoor configuration bank.
// Assumes a 3-bit port offset and byte-wide configuration data.
package tdc_pkg;

    // Unlock tracker state
    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_ONE  = 2'd1,
        TRK_TWO  = 2'd2
    } trk_e;

    // Port offsets whose meaning the block decodes
    localparam logic [2:0] OFF_RDT   = 3'd0;  // read timing (open)
    localparam logic [2:0] OFF_PROBE = 3'd1;  // unlock read / write timing
    localparam logic [2:0] OFF_KEY   = 3'd2;  // open / close key
    localparam logic [2:0] OFF_CTL   = 3'd3;  // control register
    localparam logic [2:0] OFF_STRAP = 3'd5;  // strap probe
    localparam logic [2:0] OFF_MISC  = 3'd6;  // device number / address setup

    // Key and command values
    localparam logic [7:0] KEY_OPEN   = 8'h03;
    localparam logic [7:0] KEY_CLOSE  = 8'h83;
    localparam logic [7:0] CTL_COMMIT = 8'h85;
    localparam logic [7:0] STRAP_ARM  = 8'hFF;

endpackage

// File: rtl/tdc_unlock_seq.sv
// Trapdoor unlock tracker. Watches locked accesses for the sequence
// wide read @probe, wide read @probe, byte write KEY_OPEN @key.
// Any other access resets the tracker. While open, only a byte write of
// KEY_CLOSE at the key offset closes the port.
// Assumes at most one access per cycle.
module tdc_unlock_seq
    import tdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       acc_wide,
    input  logic [2:0] acc_off,
    input  logic [7:0] acc_wdata,
    output logic       cfg_open
);

    trk_e trk_q;
    logic is_probe;
    logic is_key_wr;

    // Decode the two access shapes the sequence depends on
    always_comb begin
        is_probe  = !acc_write && acc_wide && (acc_off == OFF_PROBE);
        is_key_wr = acc_write && !acc_wide && (acc_off == OFF_KEY);
    end

    // Advance the tracker and the open flag on each access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q    <= TRK_IDLE;
            cfg_open <= 1'b0;
        end else if (acc_valid) begin
            if (cfg_open) begin
                trk_q <= TRK_IDLE;
                if (is_key_wr && (acc_wdata == KEY_CLOSE))
                    cfg_open <= 1'b0;
            end else if (is_probe) begin
                trk_q <= (trk_q == TRK_IDLE) ? TRK_ONE : TRK_TWO;
            end else begin
                trk_q <= TRK_IDLE;
                if (is_key_wr && (acc_wdata == KEY_OPEN) && (trk_q == TRK_TWO))
                    cfg_open <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdc_strap_probe.sv
// Strap probe. A byte write of STRAP_ARM at the strap offset arms it.
// The next access, if it is a wide read at the strap offset, is a strap
// hit. Every access clears the armed flag.
// Works the same whether the port is locked or open.
module tdc_strap_probe
    import tdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       acc_wide,
    input  logic [2:0] acc_off,
    input  logic [7:0] acc_wdata,
    output logic       strap_hit
);

    logic armed_q;
    logic arm_wr;

    // Recognise the arming write
    always_comb begin
        arm_wr = acc_write && !acc_wide && (acc_off == OFF_STRAP) &&
                 (acc_wdata == STRAP_ARM);
    end

    // Armed flag lives for exactly one following access
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (acc_valid)
            armed_q <= arm_wr;
    end

    // The current access is the armed strap read
    always_comb begin
        strap_hit = armed_q && acc_valid && !acc_write && acc_wide &&
                    (acc_off == OFF_STRAP);
    end

endmodule

// File: rtl/tdc_cfg_regs.sv
// Configuration register storage. Per-device read, write and address
// setup timing, a shared control register, and the misc-offset phase
// that alternates device number and address setup.
// Assumes writes arrive only as byte writes while the port is open.
module tdc_cfg_regs
    import tdc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_DEV = 2,
    localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_open,
    input  logic                             acc_valid,
    input  logic                             acc_write,
    input  logic                             acc_wide,
    input  logic [2:0]                       acc_off,
    input  logic [DATA_W-1:0]                acc_wdata,
    output logic [NUM_DEV-1:0][DATA_W-1:0]   rd_t,
    output logic [NUM_DEV-1:0][DATA_W-1:0]   wr_t,
    output logic [NUM_DEV-1:0][DATA_W-1:0]   ad_t,
    output logic                             override,
    output logic [DATA_W-1:0]                cfg_rdata
);

    logic             wr_en;
    logic             misc_wr;
    logic             misc_phase_q;
    logic [DEV_W-1:0] cur_dev_q;
    logic [DATA_W-1:0] ctl_q;

    // Qualify writes that may touch configuration state
    always_comb begin
        wr_en   = cfg_open && acc_valid && acc_write && !acc_wide;
        misc_wr = wr_en && (acc_off == OFF_MISC);
    end

    // Misc phase: 0 expects a device number, 1 expects address setup
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_open)
            misc_phase_q <= 1'b0;
        else if (misc_wr)
            misc_phase_q <= !misc_phase_q;
    end

    // Latch the device number on the first misc write of a pair
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_dev_q <= '0;
        else if (misc_wr && !misc_phase_q)
            cur_dev_q <= acc_wdata[DEV_W-1:0];
    end

    // Control register; its value decides the override
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_en && (acc_off == OFF_CTL))
            ctl_q <= acc_wdata;
    end

    assign override = (ctl_q == DATA_W'(CTL_COMMIT));

    // One register triple per device, updated when that device is latched
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        logic sel;
        assign sel = (cur_dev_q == DEV_W'(g));

        // Per-device timing storage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_t[g] <= '0;
                wr_t[g] <= '0;
                ad_t[g] <= '0;
            end else if (wr_en && sel) begin
                if (acc_off == OFF_RDT)
                    rd_t[g] <= acc_wdata;
                if (acc_off == OFF_PROBE)
                    wr_t[g] <= acc_wdata;
                if (misc_wr && misc_phase_q)
                    ad_t[g] <= acc_wdata;
            end
        end
    end

    // Read-back of the latched device's registers while open
    always_comb begin
        case (acc_off)
            OFF_RDT:   cfg_rdata = rd_t[cur_dev_q];
            OFF_PROBE: cfg_rdata = wr_t[cur_dev_q];
            OFF_CTL:   cfg_rdata = ctl_q;
            OFF_MISC:  cfg_rdata = ad_t[cur_dev_q];
            default:   cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tdc_timing_out.sv
// Active timing selection. Chooses between strap defaults and programmed
// values, picks the addressed device's data timings, and reduces the
// per-device address-setup values to their maximum (the slower one).
// Purely combinational.
module tdc_timing_out #(
    parameter int          DATA_W      = 8,
    parameter int          NUM_DEV     = 2,
    parameter logic [7:0]  DFLT_DATA_0 = 8'h66,
    parameter logic [7:0]  DFLT_DATA_1 = 8'h55,
    parameter logic [7:0]  DFLT_ADDR_0 = 8'h30,
    parameter logic [7:0]  DFLT_ADDR_1 = 8'h20,
    localparam int         DEV_W       = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                           override,
    input  logic                           strap_clk,
    input  logic [DEV_W-1:0]               dev_sel,
    input  logic [NUM_DEV-1:0][DATA_W-1:0] rd_t,
    input  logic [NUM_DEV-1:0][DATA_W-1:0] wr_t,
    input  logic [NUM_DEV-1:0][DATA_W-1:0] ad_t,
    output logic [DATA_W-1:0]              rd_timing,
    output logic [DATA_W-1:0]              wr_timing,
    output logic [DATA_W-1:0]              addr_setup
);

    logic [DATA_W-1:0] ad_max;
    logic [DATA_W-1:0] dflt_data;
    logic [DATA_W-1:0] dflt_addr;

    // Slowest address setup across all devices
    always_comb begin
        ad_max = ad_t[0];
        for (int i = 1; i < NUM_DEV; i++)
            if (ad_t[i] > ad_max)
                ad_max = ad_t[i];
    end

    // Strap defaults for the strapped clock
    always_comb begin
        dflt_data = strap_clk ? DATA_W'(DFLT_DATA_1) : DATA_W'(DFLT_DATA_0);
        dflt_addr = strap_clk ? DATA_W'(DFLT_ADDR_1) : DATA_W'(DFLT_ADDR_0);
    end

    // Final selection between programmed values and defaults
    always_comb begin
        if (override) begin
            rd_timing  = rd_t[dev_sel];
            wr_timing  = wr_t[dev_sel];
            addr_setup = ad_max;
        end else begin
            rd_timing  = dflt_data;
            wr_timing  = dflt_data;
            addr_setup = dflt_addr;
        end
    end

endmodule

// File: rtl/trapdoor_cfg_bank.sv
// Top of the trapdoor configuration bank. Routes accesses either to the
// task file (locked) or to the hidden configuration registers (open),
// serves the strap probe, and drives the active timings.
// Assumes one access per cycle and combinational read data.
module trapdoor_cfg_bank #(
    parameter int         BUS_W       = 16,
    parameter int         DATA_W      = 8,
    parameter int         NUM_DEV     = 2,
    parameter logic [7:0] DFLT_DATA_0 = 8'h66,
    parameter logic [7:0] DFLT_DATA_1 = 8'h55,
    parameter logic [7:0] DFLT_ADDR_0 = 8'h30,
    parameter logic [7:0] DFLT_ADDR_1 = 8'h20,
    localparam int        DEV_W       = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_wide,
    input  logic [2:0]        acc_off,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [BUS_W-1:0]  acc_rdata,
    output logic              tf_access,
    input  logic [BUS_W-1:0]  tf_rdata,
    input  logic              strap_clk,
    input  logic [DEV_W-1:0]  dev_sel,
    output logic              cfg_open,
    output logic [DATA_W-1:0] rd_timing,
    output logic [DATA_W-1:0] wr_timing,
    output logic [DATA_W-1:0] addr_setup,
    output logic              strap_override
);

    logic                           strap_hit;
    logic [NUM_DEV-1:0][DATA_W-1:0] rd_t;
    logic [NUM_DEV-1:0][DATA_W-1:0] wr_t;
    logic [NUM_DEV-1:0][DATA_W-1:0] ad_t;
    logic [DATA_W-1:0]              cfg_rdata;

    tdc_unlock_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_wide  (acc_wide),
        .acc_off   (acc_off),
        .acc_wdata (acc_wdata[7:0]),
        .cfg_open  (cfg_open)
    );

    tdc_strap_probe u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_wide  (acc_wide),
        .acc_off   (acc_off),
        .acc_wdata (acc_wdata[7:0]),
        .strap_hit (strap_hit)
    );

    tdc_cfg_regs #(
        .DATA_W  (DATA_W),
        .NUM_DEV (NUM_DEV)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_open  (cfg_open),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_wide  (acc_wide),
        .acc_off   (acc_off),
        .acc_wdata (acc_wdata),
        .rd_t      (rd_t),
        .wr_t      (wr_t),
        .ad_t      (ad_t),
        .override  (strap_override),
        .cfg_rdata (cfg_rdata)
    );

    tdc_timing_out #(
        .DATA_W      (DATA_W),
        .NUM_DEV     (NUM_DEV),
        .DFLT_DATA_0 (DFLT_DATA_0),
        .DFLT_DATA_1 (DFLT_DATA_1),
        .DFLT_ADDR_0 (DFLT_ADDR_0),
        .DFLT_ADDR_1 (DFLT_ADDR_1)
    ) u_out (
        .override   (strap_override),
        .strap_clk  (strap_clk),
        .dev_sel    (dev_sel),
        .rd_t       (rd_t),
        .wr_t       (wr_t),
        .ad_t       (ad_t),
        .rd_timing  (rd_timing),
        .wr_timing  (wr_timing),
        .addr_setup (addr_setup)
    );

    // Pass-through to the task file only while locked and not a strap read
    always_comb begin
        tf_access = acc_valid && !cfg_open && !strap_hit;
    end

    // Read data source: strap probe, configuration bank, or task file
    always_comb begin
        if (strap_hit)
            acc_rdata = {{(BUS_W-1){1'b0}}, strap_clk};
        else if (cfg_open)
            acc_rdata = {{(BUS_W-DATA_W){1'b0}}, cfg_rdata};
        else
            acc_rdata = tf_rdata;
    end

endmodule

// File: rtl/tdc_chk.sv
// Protocol checker for trapdoor_cfg_bank, attached by bind.
// Observes only the top-level ports.
module tdc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       acc_write,
    input logic       acc_wide,
    input logic [2:0] acc_off,
    input logic [7:0] acc_wdata,
    input logic       tf_access,
    input logic       cfg_open,
    input logic       strap_override
);

    // R2
    open_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(acc_valid && acc_write && !acc_wide &&
                                  acc_off == 3'd2 && acc_wdata == 8'h03));

    // R3
    stay_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && !(acc_valid && acc_write && !acc_wide && acc_off == 3'd2))
        |=> !cfg_open);

    // R9
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && acc_valid && acc_write && !acc_wide && acc_off == 3'd2 &&
         acc_wdata == 8'h83) |=> !cfg_open);

    // R12
    no_tf_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open |-> !tf_access);

    // R7
    override_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(strap_override));

endmodule

bind trapdoor_cfg_bank tdc_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_valid      (acc_valid),
    .acc_write      (acc_write),
    .acc_wide       (acc_wide),
    .acc_off        (acc_off),
    .acc_wdata      (acc_wdata),
    .tf_access      (tf_access),
    .cfg_open       (cfg_open),
    .strap_override (strap_override)
);

// File: tb/tb_trapdoor_cfg_bank.sv
module tb_trapdoor_cfg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_wide = 1'b0;
    logic [2:0]  acc_off = 3'd0;
    logic [7:0]  acc_wdata = 8'h00;
    logic [15:0] acc_rdata;
    logic        tf_access;
    logic [15:0] tf_rdata = 16'hBEEF;
    logic        strap_clk = 1'b0;
    logic        dev_sel = 1'b0;
    logic        cfg_open;
    logic [7:0]  rd_timing, wr_timing, addr_setup;
    logic        strap_override;

    int n_chk = 0;
    int n_fail = 0;
    logic        obs_tf;
    logic [15:0] obs_rd;

    always #2 clk = !clk;

    trapdoor_cfg_bank dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_wide(acc_wide), .acc_off(acc_off), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .tf_access(tf_access), .tf_rdata(tf_rdata),
        .strap_clk(strap_clk), .dev_sel(dev_sel), .cfg_open(cfg_open),
        .rd_timing(rd_timing), .wr_timing(wr_timing), .addr_setup(addr_setup),
        .strap_override(strap_override)
    );

    typedef struct packed {
        logic       w;
        logic       wd;
        logic [2:0] off;
        logic [7:0] d;
        logic       tf;
        logic       op;
    } vec_t;

    // Unlock / relock sequences: access, expected tf_access, expected open after
    localparam vec_t VEC [18] = '{
        '{1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd0, 8'h00, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd2, 8'h03, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd2, 8'h03, 1'b1, 1'b1},
        '{1'b1, 1'b0, 3'd2, 8'h83, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
        '{1'b0, 1'b0, 3'd1, 8'h00, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd2, 8'h03, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
        '{1'b1, 1'b1, 3'd2, 8'h03, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd2, 8'h03, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, sample combinational outputs, hold over posedge
    task automatic acc(input logic w, input logic wd, input logic [2:0] o, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_wide = wd; acc_off = o; acc_wdata = d;
        #1;
        obs_tf = tf_access;
        obs_rd = acc_rdata;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic do_unlock();
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b1, 1'b0, 3'd2, 8'h03);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 open after reset", 16'(cfg_open), 16'h0);
        chk("R1 override after reset", 16'(strap_override), 16'h0);
        chk("R1 default rd", 16'(rd_timing), 16'h66);
        chk("R1 default wr", 16'(wr_timing), 16'h66);
        chk("R1 default addr", 16'(addr_setup), 16'h30);

        // R2 R3 R9 R4: unlock sequence table
        for (int i = 0; i < 18; i++) begin
            acc(VEC[i].w, VEC[i].wd, VEC[i].off, VEC[i].d);
            chk($sformatf("R2/R3/R9 tf_access vec %0d", i), 16'(obs_tf), 16'(VEC[i].tf));
            chk($sformatf("R2/R3/R9 open vec %0d", i), 16'(cfg_open), 16'(VEC[i].op));
            if (!VEC[i].w && VEC[i].tf)
                chk($sformatf("R4 pass-through read vec %0d", i), obs_rd, 16'hBEEF);
        end

        // R6 R5: program device 0 then device 1 (port is open)
        acc(1'b1, 1'b0, 3'd6, 8'h00);
        chk("R12 open write tf", 16'(obs_tf), 16'h0);
        acc(1'b1, 1'b0, 3'd0, 8'h42);
        acc(1'b1, 1'b0, 3'd1, 8'h41);
        acc(1'b1, 1'b0, 3'd6, 8'h10);
        acc(1'b1, 1'b0, 3'd6, 8'h01);
        acc(1'b1, 1'b0, 3'd0, 8'h32);
        acc(1'b1, 1'b0, 3'd1, 8'h31);
        acc(1'b1, 1'b0, 3'd6, 8'h20);
        acc(1'b0, 1'b0, 3'd0, 8'h00);
        chk("R5 readback dev1 rd", obs_rd, 16'h0032);
        chk("R12 open read tf", 16'(obs_tf), 16'h0);
        acc(1'b0, 1'b0, 3'd6, 8'h00);
        chk("R6 readback dev1 addr", obs_rd, 16'h0020);
        chk("R7 no override yet", 16'(rd_timing), 16'h66);

        // R7 R8 R11: commit
        acc(1'b1, 1'b0, 3'd3, 8'h85);
        chk("R7 override set", 16'(strap_override), 16'h1);
        dev_sel = 1'b0; #1;
        chk("R11 dev0 rd", 16'(rd_timing), 16'h42);
        chk("R11 dev0 wr", 16'(wr_timing), 16'h41);
        chk("R8 addr max", 16'(addr_setup), 16'h20);
        dev_sel = 1'b1; #1;
        chk("R11 dev1 rd", 16'(rd_timing), 16'h32);
        chk("R11 dev1 wr", 16'(wr_timing), 16'h31);

        // R9 R4: relock, locked write has no effect
        acc(1'b1, 1'b0, 3'd2, 8'h83);
        chk("R9 closed", 16'(cfg_open), 16'h0);
        acc(1'b1, 1'b0, 3'd0, 8'h99);
        chk("R4 locked write passes", 16'(obs_tf), 16'h1);
        dev_sel = 1'b0; #1;
        chk("R4 locked write ignored", 16'(rd_timing), 16'h42);
        chk("R9 values retained", 16'(strap_override), 16'h1);

        // R8 R6: reopen, dev0 address setup becomes the larger one
        do_unlock();
        chk("R2 reopened", 16'(cfg_open), 16'h1);
        acc(1'b1, 1'b0, 3'd6, 8'h00);
        acc(1'b1, 1'b0, 3'd6, 8'h40);
        chk("R8 addr max dev0", 16'(addr_setup), 16'h40);
        dev_sel = 1'b1; #1;
        chk("R8 addr shared", 16'(addr_setup), 16'h40);

        // R7: other control value restores defaults
        acc(1'b1, 1'b0, 3'd3, 8'h00);
        chk("R7 override cleared", 16'(strap_override), 16'h0);
        chk("R7 defaults rd", 16'(rd_timing), 16'h66);
        chk("R7 defaults addr", 16'(addr_setup), 16'h30);
        acc(1'b1, 1'b0, 3'd2, 8'h83);

        // R10 R1: strap probe with strap_clk = 1
        strap_clk = 1'b1;
        acc(1'b1, 1'b0, 3'd5, 8'hFF);
        chk("R10 arm write passes", 16'(obs_tf), 16'h1);
        acc(1'b0, 1'b1, 3'd5, 8'h00);
        chk("R10 strap read data", obs_rd, 16'h0001);
        chk("R10 strap read tf", 16'(obs_tf), 16'h0);
        chk("R1 default rd fast", 16'(rd_timing), 16'h55);
        chk("R1 default addr fast", 16'(addr_setup), 16'h20);
        acc(1'b0, 1'b1, 3'd5, 8'h00);
        chk("R10 disarmed read data", obs_rd, 16'hBEEF);
        acc(1'b1, 1'b0, 3'd5, 8'hFF);
        acc(1'b0, 1'b0, 3'd0, 8'h00);
        acc(1'b0, 1'b1, 3'd5, 8'h00);
        chk("R10 disarmed by access", 16'(obs_tf), 16'h1);

        // R1: reset while open
        do_unlock();
        acc(1'b1, 1'b0, 3'd3, 8'h85);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset closes", 16'(cfg_open), 16'h0);
        chk("R1 reset clears override", 16'(strap_override), 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule